// File: doc/BRIEF.md
# Mailbox Memory Write Port with Running CRC

This block sits on the slave side of a management register bus. It lets a master place 32-bit words into an embedded processor's memory. The master writes the target address and the data word as 16-bit halves. It then writes a control word that has the execute and write bits set. The block latches the word and the address and offers them on a valid/ready memory write port. After the port accepts the write, the block advances the address by one word. It then folds the four bytes of the word into a running CRC-16, one byte per clock. The master reads the CRC back and compares it against its own value for the whole transfer.

To stream a block of memory, the master loads the start address once. After that it repeats three steps for each word: the data high half, the data low half and the execute command. A control bit clears the CRC before a new block starts.

The memory write port follows valid/ready rules. Once `mem_valid` rises, it stays high, and `mem_addr` and `mem_data` stay unchanged, until the cycle in which `mem_ready` is also high. That cycle transfers the word. `mem_ready` may be held low for any number of cycles, and the busy flag stays set for that whole time. The register port has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high, and a read returns data combinationally from `reg_addr`.

Top module: `mbox_wr_port`

## Requirements
- R1: After reset, `mem_valid` is low and every register reads 0: control, CRC, both address halves and both data halves.
- R2: Registers sit at fixed word offsets from BASE (default 0x200): +0 control, +1 CRC, +2 address high half, +3 address low half, +4 data high half, +5 data low half. Bits [1:0] of the address low half are stored as 0. Every word presented on `mem_addr` therefore has bits [1:0] equal to zero.
- R3: In the control word, bit 15 is execute, bit 14 is write, bit 12 clears the CRC and bit 8 is busy. A read of the control register returns the busy flag in bit 8 and 0 in every other bit. Writing bit 8 or any other bit has no effect.
- R4: A control write with bits 15 and 14 both set produces exactly one memory write. The address is the current address register, and the data is {data high, data low}. A control write with only one of those two bits set produces no memory write.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` and `mem_data` hold their values.
- R6: Each accepted memory write adds 4 to the address register. The carry propagates from the low half into the high half. If the master writes an address half in the same cycle, the master's value wins for that half.
- R7: The CRC uses polynomial 0x1021 with initial value 0, no bit reflection and no final XOR. It covers the four bytes of each written word, most significant byte first, and accumulates across words. Busy is set from the cycle after the execute write until four clock cycles after the memory port accepts the word. When busy clears, the CRC register holds the final value. With no stall, busy lasts 5 cycles; each cycle of `mem_ready` stall adds one.
- R8: A control write with bit 12 set clears the CRC to 0 and issues no memory write. When the same write also carries execute and write, the clear applies first. The resulting CRC then covers only the new word.
- R9: Execute and CRC-clear commands that arrive while busy is set are ignored. They start no memory write and leave the CRC unchanged.
- R10: Writes to offsets outside the six registers change nothing, and reads from such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for both reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_addr | output | 32 | Word-aligned memory write address |
| mem_data | output | 32 | Memory write data |

## Verification
Two events can fall on the same clock edge. One is the CRC clear. The other is the start of a new write, whose bytes later enter the CRC. The bench provokes this with one control write that carries clear, execute and write together, issued after the CRC has been made non-zero. It judges the result by requiring that the CRC read back equals the CRC of the new word alone, starting from 0, and that exactly one memory write happened. A second collision is the arrival of a new command while an earlier write is stalled on `mem_ready`. The bench judges this by the memory write count and by a CRC that is left unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int OFF_CTRL  = 0;
  localparam int OFF_CRC   = 1;
  localparam int OFF_A_HI  = 2;
  localparam int OFF_A_LO  = 3;
  localparam int OFF_D_HI  = 4;
  localparam int OFF_D_LO  = 5;

  localparam int BIT_EXEC  = 15;
  localparam int BIT_WRITE = 14;
  localparam int BIT_CLR   = 12;
  localparam int BIT_BUSY  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CRC   = 2'd2
  } seq_state_e;

  // One byte of a non-reflected CRC-16, most significant bit first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbox_crc.sv
module mbox_crc #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        step,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc
);
  import mbox_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= '0;
    else if (clr)   crc <= '0;
    else if (step)  crc <= crc16_byte(crc, byte_in, POLY);
  end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] word_addr,
  input  logic [WORD_W-1:0] word_data,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              adv,
  output logic              crc_step,
  output logic [7:0]        crc_byte,
  output logic              busy
);
  import mbox_pkg::*;

  localparam int NBYTES = WORD_W / 8;
  localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  seq_state_e        state;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] addr_l;
  logic [WORD_W-1:0] data_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      addr_l <= '0;
      data_l <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            addr_l <= word_addr;
            data_l <= word_data;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_ready) begin
            cnt   <= '0;
            state <= ST_CRC;
          end
        end
        ST_CRC: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (state == ST_ISSUE);
    mem_addr  = addr_l;
    mem_data  = data_l;
    adv       = mem_valid && mem_ready;
    crc_step  = (state == ST_CRC);
    crc_byte  = 8'(data_l >> (8 * (NBYTES - 1 - int'(cnt))));
    busy      = (state != ST_IDLE);
  end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int REG_W = 16,
  parameter int RA_W  = 16,
  parameter int BASE  = 'h200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [RA_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 adv,
  input  logic                 busy,
  input  logic [15:0]          crc,
  output logic [2*REG_W-1:0]   word_addr,
  output logic [2*REG_W-1:0]   word_data,
  output logic                 go,
  output logic                 crc_clr
);
  import mbox_pkg::*;

  localparam int WORD_W = 2 * REG_W;
  localparam int NBYTES = WORD_W / 8;
  localparam int ALIGN  = $clog2(NBYTES);

  logic sel_ctrl, sel_crc, sel_ahi, sel_alo, sel_dhi, sel_dlo;
  logic [WORD_W-1:0] addr_q, data_q;

  always_comb begin
    sel_ctrl = (reg_addr == RA_W'(BASE + OFF_CTRL));
    sel_crc  = (reg_addr == RA_W'(BASE + OFF_CRC));
    sel_ahi  = (reg_addr == RA_W'(BASE + OFF_A_HI));
    sel_alo  = (reg_addr == RA_W'(BASE + OFF_A_LO));
    sel_dhi  = (reg_addr == RA_W'(BASE + OFF_D_HI));
    sel_dlo  = (reg_addr == RA_W'(BASE + OFF_D_LO));
  end

  always_comb begin
    go      = reg_wr && sel_ctrl && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE] && !busy;
    crc_clr = reg_wr && sel_ctrl && reg_wdata[BIT_CLR] && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (adv) addr_q <= addr_q + WORD_W'(NBYTES);
      if (reg_wr && sel_ahi) addr_q[WORD_W-1:REG_W] <= reg_wdata;
      if (reg_wr && sel_alo) addr_q[REG_W-1:0] <= {reg_wdata[REG_W-1:ALIGN], ALIGN'(0)};
      if (reg_wr && sel_dhi) data_q[WORD_W-1:REG_W] <= reg_wdata;
      if (reg_wr && sel_dlo) data_q[REG_W-1:0] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)     reg_rdata[BIT_BUSY] = busy;
    else if (sel_crc) reg_rdata = REG_W'(crc);
    else if (sel_ahi) reg_rdata = addr_q[WORD_W-1:REG_W];
    else if (sel_alo) reg_rdata = addr_q[REG_W-1:0];
    else if (sel_dhi) reg_rdata = data_q[WORD_W-1:REG_W];
    else if (sel_dlo) reg_rdata = data_q[REG_W-1:0];
  end

  assign word_addr = addr_q;
  assign word_data = data_q;

endmodule

// File: rtl/mbox_wr_port.sv
module mbox_wr_port #(
  parameter int          REG_W = 16,
  parameter int          RA_W  = 16,
  parameter int          BASE  = 'h200,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_data
);
  localparam int WORD_W = 2 * REG_W;

  logic [WORD_W-1:0] word_addr, word_data;
  logic              go, crc_clr, adv, busy, crc_step;
  logic [7:0]        crc_byte;
  logic [15:0]       crc_q;

  mbox_regs #(.REG_W(REG_W), .RA_W(RA_W), .BASE(BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .adv       (adv),
    .busy      (busy),
    .crc       (crc_q),
    .word_addr (word_addr),
    .word_data (word_data),
    .go        (go),
    .crc_clr   (crc_clr)
  );

  mbox_seq #(.WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .word_addr (word_addr),
    .word_data (word_data),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .adv       (adv),
    .crc_step  (crc_step),
    .crc_byte  (crc_byte),
    .busy      (busy)
  );

  mbox_crc #(.POLY(POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (crc_clr),
    .step    (crc_step),
    .byte_in (crc_byte),
    .crc     (crc_q)
  );

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int REG_W = 16,
  parameter int RA_W  = 16,
  parameter int BASE  = 'h200
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [RA_W-1:0]    reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [2*REG_W-1:0] mem_addr,
  input logic [2*REG_W-1:0] mem_data,
  input logic               busy,
  input logic [15:0]        crc
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == RA_W'(BASE));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  a_r7_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[12] && !busy |=> crc == 16'h0000);

  a_r9_idle_crc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ctrl_wr |=> $stable(crc));

  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !$past(busy));

endmodule

bind mbox_wr_port mbox_chk #(.REG_W(REG_W), .RA_W(RA_W), .BASE(BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .busy      (busy),
  .crc       (crc_q)
);

// File: tb/test_mbox_wr_port.sv
`timescale 1ns/1ps
module test_mbox_wr_port;

  localparam logic [15:0] A_CTRL = 16'h0200;
  localparam logic [15:0] A_CRC  = 16'h0201;
  localparam logic [15:0] A_AHI  = 16'h0202;
  localparam logic [15:0] A_ALO  = 16'h0203;
  localparam logic [15:0] A_DHI  = 16'h0204;
  localparam logic [15:0] A_DLO  = 16'h0205;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          stall_req = 0;
  int          wait_cnt = 0;
  int          n_wr = 0;
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  logic [15:0] exp_crc = '0;

  always #2.5 clk = ~clk;

  mbox_wr_port i_mbox_wr_port (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .mem_valid (mem_valid),
    .mem_ready (mem_ready), .mem_addr (mem_addr), .mem_data (mem_data)
  );

  always @(negedge clk) begin
    if (mem_valid) begin
      if (wait_cnt >= stall_req) mem_ready = 1'b1;
      else begin mem_ready = 1'b0; wait_cnt++; end
    end else begin
      mem_ready = 1'b0;
      wait_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && n_wr < 64) begin
      log_addr[n_wr] = mem_addr;
      log_data[n_wr] = mem_data;
      n_wr++;
    end
  end

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int b = 3; b >= 0; b--) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb = r[15] ^ w[8*b+i];
        r = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 1000; k++) begin
      rd(A_CTRL, v);
      if (!v[8]) break;
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    wr(A_DHI, w[31:16]);
    wr(A_DLO, w[15:0]);
    wr(A_CTRL, 16'hC000);
    wait_idle();
    exp_crc = crc_word(exp_crc, w);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 mem_valid", 32'(mem_valid), 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", 32'(v), 32'h0);
    rd(A_CRC,  v); chk("R1 crc", 32'(v), 32'h0);
    rd(A_AHI,  v); chk("R1 addr hi", 32'(v), 32'h0);
    rd(A_ALO,  v); chk("R1 addr lo", 32'(v), 32'h0);
    rd(A_DHI,  v); chk("R1 data hi", 32'(v), 32'h0);
    rd(A_DLO,  v); chk("R1 data lo", 32'(v), 32'h0);
  endtask

  task automatic t_align();
    logic [15:0] v;
    wr(A_ALO, 16'h1237);
    rd(A_ALO, v); chk("R2 low bits cleared", 32'(v), 32'h1234);
    wr(A_AHI, 16'h3FFE);
    wr(A_ALO, 16'h0000);
    rd(A_AHI, v); chk("R2 addr hi", 32'(v), 32'h3FFE);
  endtask

  task automatic t_single();
    logic [15:0] v;
    int n0 = n_wr;
    push_word(32'h1234_5678);
    chk("R4 one write", 32'(n_wr - n0), 32'd1);
    chk("R4 addr", log_addr[n0], 32'h3FFE_0000);
    chk("R4 data", log_data[n0], 32'h1234_5678);
    rd(A_CRC, v); chk("R7 crc one word", 32'(v), 32'(exp_crc));
    rd(A_ALO, v); chk("R6 addr advanced", 32'(v), 32'h0004);
  endtask

  task automatic t_stream();
    logic [15:0] v;
    int n0 = n_wr;
    stall_req = 3;
    push_word(32'hDEAD_BEEF);
    push_word(32'h0000_0001);
    push_word(32'hA5C3_0F81);
    stall_req = 0;
    chk("R5 three writes under stall", 32'(n_wr - n0), 32'd3);
    for (int k = 0; k < 3; k++)
      chk("R6 stream addr", log_addr[n0+k], 32'h3FFE_0004 + 32'(4*k));
    chk("R5 data held", log_data[n0+2], 32'hA5C3_0F81);
    rd(A_CRC, v); chk("R7 crc accumulates", 32'(v), 32'(exp_crc));
  endtask

  task automatic t_carry();
    logic [15:0] v;
    int n0 = n_wr;
    wr(A_AHI, 16'h0001);
    wr(A_ALO, 16'hFFFC);
    push_word(32'h0BAD_F00D);
    chk("R6 carry write addr", log_addr[n0], 32'h0001_FFFC);
    rd(A_AHI, v); chk("R6 carry hi", 32'(v), 32'h0002);
    rd(A_ALO, v); chk("R6 carry lo", 32'(v), 32'h0000);
  endtask

  task automatic t_noexec();
    logic [15:0] v;
    int n0 = n_wr;
    wr(A_CTRL, 16'h8000);
    wr(A_CTRL, 16'h4000);
    wr(A_CTRL, 16'h2F3F);
    repeat (10) @(negedge clk);
    chk("R4 partial command no write", 32'(n_wr - n0), 32'd0);
    rd(A_CTRL, v); chk("R3 ctrl reads busy only", 32'(v), 32'h0);
    rd(A_CRC, v); chk("R4 crc untouched", 32'(v), 32'(exp_crc));
  endtask

  task automatic t_clear();
    logic [15:0] v;
    int n0 = n_wr;
    wr(A_CTRL, 16'h1000);
    exp_crc = '0;
    repeat (6) @(negedge clk);
    rd(A_CRC, v); chk("R8 crc cleared", 32'(v), 32'h0);
    chk("R8 clear no write", 32'(n_wr - n0), 32'd0);
  endtask

  task automatic t_combo();
    logic [15:0] v;
    int n0;
    push_word(32'h5555_AAAA);
    n0 = n_wr;
    wr(A_DHI, 16'hC0FF);
    wr(A_DLO, 16'hEE42);
    wr(A_CTRL, 16'hD000);
    wait_idle();
    exp_crc = crc_word(16'h0, 32'hC0FF_EE42);
    rd(A_CRC, v); chk("R8 clear with execute", 32'(v), 32'(exp_crc));
    chk("R8 combined one write", 32'(n_wr - n0), 32'd1);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int n0, n;
    stall_req = 2;
    wr(A_DHI, 16'h1111);
    wr(A_DLO, 16'h2222);
    wr(A_CTRL, 16'hC000);
    n = 0;
    #1;
    while (reg_rdata[8] && n < 100) begin n++; @(negedge clk); #1; end
    chk("R7 busy length with 2 stall", 32'(n), 32'd7);
    exp_crc = crc_word(exp_crc, 32'h1111_2222);

    stall_req = 10;
    n0 = n_wr;
    wr(A_DLO, 16'h3333);
    wr(A_CTRL, 16'hC000);
    rd(A_CTRL, v); chk("R3 busy bit set", 32'(v), 32'h0100);
    wr(A_DLO, 16'h4444);
    wr(A_CTRL, 16'hD000);
    wait_idle();
    stall_req = 0;
    exp_crc = crc_word(exp_crc, 32'h1111_3333);
    chk("R9 command while busy ignored", 32'(n_wr - n0), 32'd1);
    chk("R9 first data kept", log_data[n0], 32'h1111_3333);
    rd(A_CRC, v); chk("R9 clear while busy ignored", 32'(v), 32'(exp_crc));
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    wr(16'h0206, 16'hFFFF);
    wr(16'h01FF, 16'hFFFF);
    rd(16'h0206, v); chk("R10 read unknown", 32'(v), 32'h0);
    rd(A_DLO, v); chk("R10 data lo unchanged", 32'(v), 32'h4444);
    rd(A_CRC, v); chk("R10 crc unchanged", 32'(v), 32'(exp_crc));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_align();
    t_single();
    t_stream();
    t_carry();
    t_noexec();
    t_clear();
    t_combo();
    t_busy();
    t_unknown();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule